// File: doc/BRIEF.md
# Address Pin Connection Decoder

This block works out, for each of two address-select pins, what the pin is wired to: ground, the supply, the bus data line (SDA) or the bus clock line (SCL). Because a pin tied to a bus line carries the same waveform as that line, the block watches live bus traffic to tell it apart from a fixed level. Every transmission on the bus is used for this, including transmissions meant for other devices. A board can therefore change the straps without cycling power.

A bus monitor supplies one-cycle start and stop strobes, and a void strobe when a transaction is abandoned. SDA, SCL and both pins are expected to be already synchronous to `clk`. During a transmission, the decoder samples each pin at every SCL edge and at every SDA change, starting in the start-strobe cycle. It keeps one tally per pin: whether the pin always matched SCL, whether it always matched SDA, and which levels it took. At a stop strobe the decoder turns each tally into a 2-bit connection code and registers the result. The codes are then combined into a 4-bit address nibble and into one pullup enable for each group of four inputs.

At power-up no traffic has been seen yet, and both bus lines idle high. For that reason, both pins start out reported as tied to the supply.

Top module: `addr_pin_decoder`

## Requirements
- R1: After reset, both connection codes read 01 (supply), the address nibble reads 0101 and both pullup enables read 1.
- R2: The codes are ground=00, supply=01, SCL=10 and SDA=11. A pin that equals SCL at every sample of a transmission is coded 10.
- R3: A pin that does not always equal SCL, but equals SDA at every sample of a transmission, is coded 11.
- R4: A pin that matches neither bus line and was 1 at every sample is coded 01. If it was 0 at every sample, it is coded 00.
- R5: A new code appears in the cycle after the stop-strobe cycle. Until then, and in particular during the transmission, the outputs keep their previous values.
- R6: A void strobe discards the transmission in progress and leaves all outputs unchanged. A stop strobe with no transmission open is ignored.
- R7: The address nibble is {pin-B code, pin-A code}, with the pin-B code in bits 3:2.
- R8: Pullup enable bit 0 (inputs 0 to 3) follows pin A and bit 1 (inputs 4 to 7) follows pin B. A bit is 0 only when its pin is coded ground; the other three codes give 1.
- R9: Every completed transmission re-evaluates both pins, whatever the data it carries. A strap changed between transmissions is reported after the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| adr_pin_a | input | 1 | Address-select pin A, the level seen on the pin |
| adr_pin_b | input | 1 | Address-select pin B, the level seen on the pin |
| sda | input | 1 | Bus data line, synchronised |
| scl | input | 1 | Bus clock line, synchronised |
| start_stb | input | 1 | One-cycle pulse from the bus monitor on a start condition |
| stop_stb | input | 1 | One-cycle pulse from the bus monitor on a stop condition |
| void_stb | input | 1 | One-cycle pulse that abandons the current transmission |
| conn_a | output | 2 | Connection code of pin A |
| conn_b | output | 2 | Connection code of pin B |
| addr_nib | output | 4 | Address nibble derived from both codes |
| pu_en | output | 2 | Pullup enables, bit 0 for inputs 0-3, bit 1 for inputs 4-7 |

## Verification
The hardest case to reach is a pin that follows a bus line. It can only be told apart from a fixed level if the bus moves in a real transmission shape: a start, SCL edges and SDA changes kept apart, then a stop. The bench therefore models each pin as a wire whose value is computed from its strap mode and the current SDA and SCL. It drives full bit-level transmissions carrying varied data bytes, and it changes the straps between them. An abandoned transmission, followed by a stray stop, shows that a partial tally is never committed.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef enum logic [1:0] {
    CONN_GND = 2'b00,
    CONN_VDD = 2'b01,
    CONN_SCL = 2'b10,
    CONN_SDA = 2'b11
  } conn_e;

  localparam conn_e CONN_POWERUP = CONN_VDD;
endpackage

// File: rtl/apd_bus_window.sv
// Tracks whether a transmission is open and produces the sampling,
// tally-clear and commit strobes shared by all pin classifiers.
module apd_bus_window (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic void_i,
  output logic sample_o,
  output logic init_o,
  output logic commit_o
);
  logic active_q, active_d;
  logic sda_q, scl_q;
  logic bus_edge;

  always_comb begin
    active_d = active_q;
    if (void_i)       active_d = 1'b0;
    else if (start_i) active_d = 1'b1;
    else if (stop_i)  active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sda_q    <= 1'b1;
      scl_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      sda_q    <= sda_i;
      scl_q    <= scl_i;
    end
  end

  assign bus_edge = (sda_i != sda_q) || (scl_i != scl_q);
  assign sample_o = (start_i || active_q) && bus_edge && !void_i;
  assign init_o   = start_i && !active_q && !void_i;
  assign commit_o = stop_i && active_q && !void_i && !start_i;

  AST_OPEN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(start_i)); // R9
endmodule

// File: rtl/apd_pin_class.sv
// Per-pin tally of the samples taken during one transmission, and the
// registered connection code that the tally produces at the stop.
module apd_pin_class
  import apd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_i,
  input  logic  sda_i,
  input  logic  scl_i,
  input  logic  sample_i,
  input  logic  init_i,
  input  logic  commit_i,
  output conn_e conn_o
);
  logic  eq_scl_q, eq_sda_q, saw_hi_q, saw_lo_q, any_q;
  logic  eq_scl_d, eq_sda_d, saw_hi_d, saw_lo_d, any_d;
  logic  tally_en;
  conn_e conn_q, conn_d;

  // Next-state logic for the tally flags.
  always_comb begin
    eq_scl_d = eq_scl_q;
    eq_sda_d = eq_sda_q;
    saw_hi_d = saw_hi_q;
    saw_lo_d = saw_lo_q;
    any_d    = any_q;
    if (init_i) begin
      eq_scl_d = 1'b1;
      eq_sda_d = 1'b1;
      saw_hi_d = 1'b0;
      saw_lo_d = 1'b0;
      any_d    = 1'b0;
    end
    if (sample_i) begin
      eq_scl_d = eq_scl_d && (pin_i == scl_i);
      eq_sda_d = eq_sda_d && (pin_i == sda_i);
      saw_hi_d = saw_hi_d || pin_i;
      saw_lo_d = saw_lo_d || !pin_i;
      any_d    = 1'b1;
    end
  end

  // Classification at commit. SCL wins over SDA. A pin that toggled
  // without following a bus line keeps its previous code.
  always_comb begin
    conn_d = conn_q;
    if (commit_i && any_d) begin
      if (eq_scl_d)                  conn_d = CONN_SCL;
      else if (eq_sda_d)             conn_d = CONN_SDA;
      else if (saw_hi_d && !saw_lo_d) conn_d = CONN_VDD;
      else if (saw_lo_d && !saw_hi_d) conn_d = CONN_GND;
    end
  end

  assign tally_en = init_i || sample_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_scl_q <= 1'b1;
      eq_sda_q <= 1'b1;
      saw_hi_q <= 1'b0;
      saw_lo_q <= 1'b0;
      any_q    <= 1'b0;
    end else if (tally_en) begin
      eq_scl_q <= eq_scl_d;
      eq_sda_q <= eq_sda_d;
      saw_hi_q <= saw_hi_d;
      saw_lo_q <= saw_lo_d;
      any_q    <= any_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        conn_q <= CONN_POWERUP;
    else if (commit_i) conn_q <= conn_d;
  end

  assign conn_o = conn_q;

  AST_HOLD_OUTSIDE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(conn_q)); // R5
endmodule

// File: rtl/apd_pullup_map.sv
// Maps each group's connection code to its pullup enable.
module apd_pullup_map
  import apd_pkg::*;
#(
  parameter int NGRP = 2
) (
  input  logic [2*NGRP-1:0] conn_i,
  output logic [NGRP-1:0]   pu_en_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign pu_en_o[g] = (conn_i[2*g +: 2] != CONN_GND);
  end
endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
  import apd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adr_pin_a,
  input  logic       adr_pin_b,
  input  logic       sda,
  input  logic       scl,
  input  logic       start_stb,
  input  logic       stop_stb,
  input  logic       void_stb,
  output logic [1:0] conn_a,
  output logic [1:0] conn_b,
  output logic [3:0] addr_nib,
  output logic [1:0] pu_en
);
  localparam int NPIN = 2;
  localparam int CW   = 2;

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_sync_n;
  logic                   sample_w, init_w, commit_w;
  logic [NPIN-1:0]        pin_w;
  conn_e                  conn_w [NPIN];
  logic [NPIN*CW-1:0]     conn_flat;

  // Reset asserts at once and is released in step with the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[SYNC_STAGES-1];

  apd_bus_window u_win (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sda_i    (sda),
    .scl_i    (scl),
    .start_i  (start_stb),
    .stop_i   (stop_stb),
    .void_i   (void_stb),
    .sample_o (sample_w),
    .init_o   (init_w),
    .commit_o (commit_w)
  );

  assign pin_w = {adr_pin_b, adr_pin_a};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    apd_pin_class u_cls (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .pin_i    (pin_w[g]),
      .sda_i    (sda),
      .scl_i    (scl),
      .sample_i (sample_w),
      .init_i   (init_w),
      .commit_i (commit_w),
      .conn_o   (conn_w[g])
    );
    assign conn_flat[CW*g +: CW] = conn_w[g];
  end

  apd_pullup_map #(.NGRP(NPIN)) u_pu (
    .conn_i  (conn_flat),
    .pu_en_o (pu_en)
  );

  assign conn_a   = conn_flat[CW-1:0];
  assign conn_b   = conn_flat[2*CW-1:CW];
  assign addr_nib = conn_flat;

  AST_VOID_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    void_stb |=> ($stable(conn_a) && $stable(conn_b))); // R6
  AST_PU_A_GROUND_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (conn_a == 2'b00) |-> !pu_en[0]); // R8
  AST_PU_B_GROUND_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (conn_b == 2'b00) |-> !pu_en[1]); // R8
endmodule

// File: tb/addr_pin_decoder_bench.sv
module addr_pin_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sda, scl, start_stb, stop_stb, void_stb;
  logic [1:0] mode_a, mode_b;
  logic       adr_pin_a, adr_pin_b;
  logic [1:0] conn_a, conn_b, pu_en;
  logic [3:0] addr_nib;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] exp_q[$];
  logic [1:0] cur_a, cur_b;
  event txn_done;

  always #5 clk = ~clk;

  // Strap model: 00 ground, 01 supply, 10 tied to SCL, 11 tied to SDA.
  function automatic logic strap(input logic [1:0] m, input logic d, input logic c);
    case (m)
      2'b00:   strap = 1'b0;
      2'b01:   strap = 1'b1;
      2'b10:   strap = c;
      default: strap = d;
    endcase
  endfunction

  assign adr_pin_a = strap(mode_a, sda, scl);
  assign adr_pin_b = strap(mode_b, sda, scl);

  addr_pin_decoder u_addr_pin_decoder (
    .clk(clk), .rst_n(rst_n), .adr_pin_a(adr_pin_a), .adr_pin_b(adr_pin_b),
    .sda(sda), .scl(scl), .start_stb(start_stb), .stop_stb(stop_stb),
    .void_stb(void_stb), .conn_a(conn_a), .conn_b(conn_b),
    .addr_nib(addr_nib), .pu_en(pu_en)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(input logic [1:0] ea, input logic [1:0] eb, input string ctx);
    check({ctx, " R2 R3 R4 conn_a"}, {2'b00, conn_a}, {2'b00, ea});
    check({ctx, " R9 conn_b"}, {2'b00, conn_b}, {2'b00, eb});
    check({ctx, " R7 addr_nib"}, addr_nib, {eb, ea});
    check({ctx, " R8 pu_en"}, {2'b00, pu_en}, {2'b00, (eb != 2'b00), (ea != 2'b00)});
  endtask

  task automatic step(input logic d, input logic c);
    @(negedge clk);
    sda = d; scl = c;
  endtask

  // One transmission: start, 9 clocked bits, then stop or a void.
  task automatic run_txn(input logic [7:0] data, input logic do_void);
    @(negedge clk);
    sda = 1'b0; start_stb = 1'b1;
    @(negedge clk);
    start_stb = 1'b0;
    for (int i = 8; i >= 0; i--) begin
      step(sda, 1'b0);
      step((i == 0) ? 1'b0 : data[i-1], 1'b0);
      step(sda, 1'b1);
      if (i == 5) begin
        // R5: nothing visible mid-transmission.
        check_all(cur_a, cur_b, "mid-txn R5");
        if (do_void) break;
      end
    end
    if (do_void) begin
      @(negedge clk); void_stb = 1'b1;
      @(negedge clk); void_stb = 1'b0;
      step(1'b1, 1'b1);
      @(negedge clk);
      exp_q.push_back({cur_a, cur_b});
      -> txn_done;
      // R6: stray stop with no open transmission.
      @(negedge clk); stop_stb = 1'b1;
      @(negedge clk); stop_stb = 1'b0;
      exp_q.push_back({cur_a, cur_b});
      -> txn_done;
    end else begin
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      @(negedge clk);
      sda = 1'b1; stop_stb = 1'b1;
      @(negedge clk);
      stop_stb = 1'b0;
      cur_a = mode_a; cur_b = mode_b;
      exp_q.push_back({cur_a, cur_b});
      -> txn_done;
    end
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(txn_done);
      if (exp_q.size() > 0) begin
        logic [3:0] it;
        it = exp_q.pop_front();
        check_all(it[3:2], it[1:0], "scoreboard R5 R6");
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog R5 act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sda = 1'b1; scl = 1'b1;
    start_stb = 1'b0; stop_stb = 1'b0; void_stb = 1'b0;
    mode_a = 2'b10; mode_b = 2'b11;
    cur_a = 2'b01; cur_b = 2'b01;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all(2'b01, 2'b01, "reset R1");

    run_txn(8'hA5, 1'b0);           // SCL / SDA
    mode_a = 2'b00; mode_b = 2'b01;
    run_txn(8'h3C, 1'b0);           // ground / supply
    mode_a = 2'b11; mode_b = 2'b10;
    run_txn(8'h00, 1'b0);           // SDA / SCL
    mode_a = 2'b01; mode_b = 2'b00;
    run_txn(8'hFF, 1'b0);           // supply / ground
    mode_a = 2'b10; mode_b = 2'b10;
    run_txn(8'h5A, 1'b1);           // voided: nothing changes
    mode_a = 2'b00; mode_b = 2'b00;
    run_txn(8'h81, 1'b0);           // ground / ground

    // Power-on reset mid-life restores the power-up assumption (R1).
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_a = 2'b01; cur_b = 2'b01;
    check_all(2'b01, 2'b01, "re-reset R1");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule